// File: doc/BRIEF.md
# Guest TLB Indexed Write Unit

This block holds a small guest address-translation array and commits one indexed write per strobe. The write data comes from register-style inputs: an index, an entry-high word (VPN2, ASID, region bits and an invalidate flag), two entry-low words (one per page of the even/odd pair, each with PFN, cache attribute, dirty, valid and global bits), a page mask, and a root guest-ID value. Capability and enable flags decide whether the write may happen at all. The write clears masked VPN and PFN bits, folds the two global bits into one, and applies the hardware-invalid and guest-ID rules before it stores the entry.

For each strobe, exactly one outcome flag is raised in the following cycle. The possible outcomes are coprocessor-unusable, reserved-instruction, index error, machine check, or write done. When a write completes, any other live entry that would translate the same page is invalidated in the same clock edge. A combinational read port returns any stored entry by index.

Top module: `tlbgw_top`

## Requirements
- R1: When `wr_stb` is 1 and `cop_en` is 0, `cu_o` is 1 in the next cycle and no entry changes.
- R2: When `cop_en` is 1 and `vz_cap` is 0, a strobe raises `ri_o` in the next cycle and no entry changes.
- R3: The stored global bit is the AND of `lo0_g` and `lo1_g`.
- R4: The stored VPN2, PFN0 and PFN1 have every bit cleared where the corresponding `pg_mask` bit is 1 (mask bit k lines up with bit k of each field). `pg_mask` itself is stored.
- R5: The stored ASID and region bits come from `eh_asid` and `eh_r`. The even-page cache attribute, dirty and valid bits come from the `lo0_*` inputs, and the odd-page ones from the `lo1_*` inputs.
- R6: When `inv_lvl` is 2 or higher, the stored hardware-invalid bit equals `eh_inv`. Otherwise the entry keeps its previous hardware-invalid value.
- R7: The stored guest ID is `root_gid` when `gid_en` is 1. Otherwise the entry keeps its previous guest ID.
- R8: Indices from `VAR_ENTRIES` up to `NUM_ENTRIES-1` form the fixed-size region. For such an index, the write is faulty if `pg_mask` differs from `FIX_MASK`, or if the low log2(NUM_ENTRIES-VAR_ENTRIES) bits of `eh_vpn2` differ from (index - VAR_ENTRIES). A faulty write raises `mcheck_o` and leaves the array unchanged, unless `eh_inv` is 1. In that case no machine check is raised and the write completes.
- R9: When a write completes with `eh_inv`=0, every other entry that matches the new entry is set hardware-invalid and `dup_o` is 1 alongside `done_o`. An entry matches if it is not hardware-invalid, its region bits and guest ID equal the new entry's, its ASID equals the new one or either global bit is 1, and its VPN2 equals the new one on all bits not set in either entry's mask. No machine check is raised for duplicates.
- R10: An `idx_in` at or above `NUM_ENTRIES` raises `idx_err_o` and leaves the array unchanged.
- R11: The outcome flags are registered and appear the cycle after the strobe. Priority is cu, then ri, then idx_err, then mcheck, then done, and at most one flag is high. With no strobe, all flags are 0. After reset, every entry is all zero with its hardware-invalid bit at 1.
- R12: The read port shows the entry selected by `rd_idx` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write request, one cycle |
| cop_en | input | 1 | Coprocessor access enabled |
| vz_cap | input | 1 | Virtualization capability present |
| inv_lvl | input | 2 | Invalidate capability level |
| gid_en | input | 1 | Guest-ID write enable |
| root_gid | input | 4 | Guest ID to store |
| idx_in | input | IDXI_W | Target index |
| eh_vpn2 | input | 19 | Virtual page pair number |
| eh_asid | input | 8 | Address space ID |
| eh_r | input | 2 | Region bits |
| eh_inv | input | 1 | Invalidate flag |
| lo0_pfn | input | 20 | Even page frame |
| lo0_c | input | 3 | Even page cache attribute |
| lo0_d | input | 1 | Even page dirty |
| lo0_v | input | 1 | Even page valid |
| lo0_g | input | 1 | Even page global |
| lo1_pfn | input | 20 | Odd page frame |
| lo1_c | input | 3 | Odd page cache attribute |
| lo1_d | input | 1 | Odd page dirty |
| lo1_v | input | 1 | Odd page valid |
| lo1_g | input | 1 | Odd page global |
| pg_mask | input | 8 | Page mask |
| cu_o | output | 1 | Coprocessor-unusable outcome |
| ri_o | output | 1 | Reserved-instruction outcome |
| idx_err_o | output | 1 | Index out of range |
| mcheck_o | output | 1 | Machine check outcome |
| done_o | output | 1 | Write committed |
| dup_o | output | 1 | Duplicates invalidated |
| rd_idx | input | log2(NUM_ENTRIES) | Read index |
| rd_vpn2 | output | 19 | Read VPN2 |
| rd_asid | output | 8 | Read ASID |
| rd_r | output | 2 | Read region bits |
| rd_mask | output | 8 | Read mask |
| rd_g | output | 1 | Read global |
| rd_pfn0 | output | 20 | Read even PFN |
| rd_c0 | output | 3 | Read even cache attribute |
| rd_d0 | output | 1 | Read even dirty |
| rd_v0 | output | 1 | Read even valid |
| rd_pfn1 | output | 20 | Read odd PFN |
| rd_c1 | output | 3 | Read odd cache attribute |
| rd_d1 | output | 1 | Read odd dirty |
| rd_v1 | output | 1 | Read odd valid |
| rd_gid | output | 4 | Read guest ID |
| rd_hwinv | output | 1 | Read hardware-invalid bit |

## Verification
A corrupted entry appears on the read port in the same cycle that `rd_idx` selects it, so the bench scans the whole array after every write. A wrong duplicate invalidation or a stray write to a neighbouring slot is therefore caught before the next strobe. A wrong outcome decision appears on the flags one cycle after the strobe. A write that should have been blocked shows up as a changed entry in the scan that follows.

// File: rtl/tlbgw_pkg.sv
package tlbgw_pkg;

    localparam int VPN2_W = 19;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;
    localparam int MASK_W = 8;
    localparam int CA_W   = 3;
    localparam int GID_W  = 4;
    localparam int RGN_W  = 2;

    typedef struct packed {
        logic [CA_W-1:0]  c;
        logic             d;
        logic             v;
        logic [PFN_W-1:0] pfn;
    } page_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [RGN_W-1:0]  r;
        logic [MASK_W-1:0] mask;
        logic              g;
        page_t             p0;
        page_t             p1;
        logic [GID_W-1:0]  gid;
        logic              hwinv;
    } entry_t;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_CU,
        OUT_RI,
        OUT_IDX,
        OUT_MC,
        OUT_DONE
    } outcome_t;

    function automatic entry_t reset_entry();
        entry_t e;
        e       = '0;
        e.hwinv = 1'b1;
        return e;
    endfunction

    function automatic logic [VPN2_W-1:0] vpn_span(input logic [MASK_W-1:0] m);
        return {{(VPN2_W-MASK_W){1'b0}}, m};
    endfunction

    function automatic logic [PFN_W-1:0] pfn_span(input logic [MASK_W-1:0] m);
        return {{(PFN_W-MASK_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/tlbgw_gate.sv
module tlbgw_gate
    import tlbgw_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int VAR_ENTRIES = 8,
    parameter int IDXI_W      = 6,
    parameter logic [MASK_W-1:0] FIX_MASK = 8'h03
) (
    input  logic              strobe,
    input  logic              cop_en,
    input  logic              vz_cap,
    input  logic              eh_inv,
    input  logic [IDXI_W-1:0] idx_in,
    input  logic [MASK_W-1:0] pg_mask,
    input  logic [VPN2_W-1:0] eh_vpn2,
    output outcome_t          outcome,
    output logic              commit
);
    localparam int FIX_N  = NUM_ENTRIES - VAR_ENTRIES;
    localparam int FIX_IW = (FIX_N > 1) ? $clog2(FIX_N) : 1;
    localparam logic [IDXI_W-1:0] LIMIT = IDXI_W'(NUM_ENTRIES);
    localparam logic [IDXI_W-1:0] VBASE = IDXI_W'(VAR_ENTRIES);

    logic              in_range;
    logic              in_fixed;
    logic              size_bad;
    logic              vpn_bad;
    logic              fix_fault;
    logic [IDXI_W-1:0] fix_off;

    assign in_range  = idx_in < LIMIT;
    assign in_fixed  = idx_in >= VBASE;
    assign fix_off   = idx_in - VBASE;
    assign size_bad  = pg_mask != FIX_MASK;
    assign vpn_bad   = eh_vpn2[FIX_IW-1:0] != fix_off[FIX_IW-1:0];
    assign fix_fault = in_fixed && (size_bad || vpn_bad) && !eh_inv;

    always_comb begin
        if (!strobe)         outcome = OUT_NONE;
        else if (!cop_en)    outcome = OUT_CU;
        else if (!vz_cap)    outcome = OUT_RI;
        else if (!in_range)  outcome = OUT_IDX;
        else if (fix_fault)  outcome = OUT_MC;
        else                 outcome = OUT_DONE;
    end

    assign commit = outcome == OUT_DONE;

endmodule

// File: rtl/tlbgw_compose.sv
module tlbgw_compose
    import tlbgw_pkg::*;
(
    input  logic [1:0]        inv_lvl,
    input  logic              gid_en,
    input  logic [GID_W-1:0]  root_gid,
    input  logic [VPN2_W-1:0] eh_vpn2,
    input  logic [ASID_W-1:0] eh_asid,
    input  logic [RGN_W-1:0]  eh_r,
    input  logic              eh_inv,
    input  page_t             lo0,
    input  page_t             lo1,
    input  logic              lo0_g,
    input  logic              lo1_g,
    input  logic [MASK_W-1:0] pg_mask,
    input  entry_t            prior,
    output entry_t            fresh
);
    always_comb begin
        fresh.vpn2   = eh_vpn2 & ~vpn_span(pg_mask);
        fresh.asid   = eh_asid;
        fresh.r      = eh_r;
        fresh.mask   = pg_mask;
        fresh.g      = lo0_g & lo1_g;
        fresh.p0     = lo0;
        fresh.p0.pfn = lo0.pfn & ~pfn_span(pg_mask);
        fresh.p1     = lo1;
        fresh.p1.pfn = lo1.pfn & ~pfn_span(pg_mask);
        fresh.gid    = gid_en ? root_gid : prior.gid;
        fresh.hwinv  = (inv_lvl >= 2'd2) ? eh_inv : prior.hwinv;
    end

endmodule

// File: rtl/tlbgw_dupscan.sv
module tlbgw_dupscan
    import tlbgw_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IW          = 4
) (
    input  entry_t                 tbl [NUM_ENTRIES],
    input  entry_t                 cand,
    input  logic [IW-1:0]          slot,
    output logic [NUM_ENTRIES-1:0] hit
);
    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        logic              vpn_eq;
        logic              asid_eq;
        logic              tag_eq;

        assign care    = ~vpn_span(tbl[k].mask | cand.mask);
        assign vpn_eq  = ((tbl[k].vpn2 ^ cand.vpn2) & care) == '0;
        assign asid_eq = tbl[k].g | cand.g | (tbl[k].asid == cand.asid);
        assign tag_eq  = (tbl[k].r == cand.r) && (tbl[k].gid == cand.gid);
        assign hit[k]  = (slot != IW'(k)) && !tbl[k].hwinv && vpn_eq && asid_eq && tag_eq;
    end

endmodule

// File: rtl/tlbgw_top.sv
module tlbgw_top
    import tlbgw_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int VAR_ENTRIES = 8,
    parameter int IDXI_W      = 6,
    parameter logic [MASK_W-1:0] FIX_MASK = 8'h03,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              cop_en,
    input  logic              vz_cap,
    input  logic [1:0]        inv_lvl,
    input  logic              gid_en,
    input  logic [GID_W-1:0]  root_gid,
    input  logic [IDXI_W-1:0] idx_in,
    input  logic [VPN2_W-1:0] eh_vpn2,
    input  logic [ASID_W-1:0] eh_asid,
    input  logic [RGN_W-1:0]  eh_r,
    input  logic              eh_inv,
    input  logic [PFN_W-1:0]  lo0_pfn,
    input  logic [CA_W-1:0]   lo0_c,
    input  logic              lo0_d,
    input  logic              lo0_v,
    input  logic              lo0_g,
    input  logic [PFN_W-1:0]  lo1_pfn,
    input  logic [CA_W-1:0]   lo1_c,
    input  logic              lo1_d,
    input  logic              lo1_v,
    input  logic              lo1_g,
    input  logic [MASK_W-1:0] pg_mask,
    output logic              cu_o,
    output logic              ri_o,
    output logic              idx_err_o,
    output logic              mcheck_o,
    output logic              done_o,
    output logic              dup_o,
    input  logic [IW-1:0]     rd_idx,
    output logic [VPN2_W-1:0] rd_vpn2,
    output logic [ASID_W-1:0] rd_asid,
    output logic [RGN_W-1:0]  rd_r,
    output logic [MASK_W-1:0] rd_mask,
    output logic              rd_g,
    output logic [PFN_W-1:0]  rd_pfn0,
    output logic [CA_W-1:0]   rd_c0,
    output logic              rd_d0,
    output logic              rd_v0,
    output logic [PFN_W-1:0]  rd_pfn1,
    output logic [CA_W-1:0]   rd_c1,
    output logic              rd_d1,
    output logic              rd_v1,
    output logic [GID_W-1:0]  rd_gid,
    output logic              rd_hwinv
);
    entry_t                 tbl [NUM_ENTRIES];
    entry_t                 prior;
    entry_t                 fresh;
    entry_t                 view;
    page_t                  lo0;
    page_t                  lo1;
    outcome_t               outcome;
    logic                   commit;
    logic                   purge;
    logic [IW-1:0]          slot;
    logic [NUM_ENTRIES-1:0] hit;

    assign slot  = idx_in[IW-1:0];
    assign prior = tbl[slot];
    assign lo0   = '{c: lo0_c, d: lo0_d, v: lo0_v, pfn: lo0_pfn};
    assign lo1   = '{c: lo1_c, d: lo1_d, v: lo1_v, pfn: lo1_pfn};
    assign purge = commit && !eh_inv;

    tlbgw_gate #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .VAR_ENTRIES (VAR_ENTRIES),
        .IDXI_W      (IDXI_W),
        .FIX_MASK    (FIX_MASK)
    ) u_gate (
        .strobe  (wr_stb),
        .cop_en  (cop_en),
        .vz_cap  (vz_cap),
        .eh_inv  (eh_inv),
        .idx_in  (idx_in),
        .pg_mask (pg_mask),
        .eh_vpn2 (eh_vpn2),
        .outcome (outcome),
        .commit  (commit)
    );

    tlbgw_compose u_compose (
        .inv_lvl  (inv_lvl),
        .gid_en   (gid_en),
        .root_gid (root_gid),
        .eh_vpn2  (eh_vpn2),
        .eh_asid  (eh_asid),
        .eh_r     (eh_r),
        .eh_inv   (eh_inv),
        .lo0      (lo0),
        .lo1      (lo1),
        .lo0_g    (lo0_g),
        .lo1_g    (lo1_g),
        .pg_mask  (pg_mask),
        .prior    (prior),
        .fresh    (fresh)
    );

    tlbgw_dupscan #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IW          (IW)
    ) u_dupscan (
        .tbl  (tbl),
        .cand (fresh),
        .slot (slot),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_ENTRIES; k++) tbl[k] <= reset_entry();
            cu_o      <= 1'b0;
            ri_o      <= 1'b0;
            idx_err_o <= 1'b0;
            mcheck_o  <= 1'b0;
            done_o    <= 1'b0;
            dup_o     <= 1'b0;
        end else begin
            cu_o      <= outcome == OUT_CU;
            ri_o      <= outcome == OUT_RI;
            idx_err_o <= outcome == OUT_IDX;
            mcheck_o  <= outcome == OUT_MC;
            done_o    <= outcome == OUT_DONE;
            dup_o     <= purge && (|hit);
            if (commit) begin
                for (int k = 0; k < NUM_ENTRIES; k++) begin
                    if (slot == IW'(k))         tbl[k]       <= fresh;
                    else if (purge && hit[k])   tbl[k].hwinv <= 1'b1;
                end
            end
        end
    end

    assign view     = tbl[rd_idx];
    assign rd_vpn2  = view.vpn2;
    assign rd_asid  = view.asid;
    assign rd_r     = view.r;
    assign rd_mask  = view.mask;
    assign rd_g     = view.g;
    assign rd_pfn0  = view.p0.pfn;
    assign rd_c0    = view.p0.c;
    assign rd_d0    = view.p0.d;
    assign rd_v0    = view.p0.v;
    assign rd_pfn1  = view.p1.pfn;
    assign rd_c1    = view.p1.c;
    assign rd_d1    = view.p1.d;
    assign rd_v1    = view.p1.v;
    assign rd_gid   = view.gid;
    assign rd_hwinv = view.hwinv;

endmodule

// File: rtl/tlbgw_props.sv
module tlbgw_props
    import tlbgw_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDXI_W      = 6,
    parameter int IW          = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic              cop_en,
    input logic              vz_cap,
    input logic              eh_inv,
    input logic [IDXI_W-1:0] idx_in,
    input logic              cu_o,
    input logic              ri_o,
    input logic              idx_err_o,
    input logic              mcheck_o,
    input logic              done_o,
    input logic              dup_o,
    input logic [IW-1:0]     rd_idx,
    input logic [VPN2_W-1:0] rd_vpn2,
    input logic              rd_hwinv
);
    localparam logic [IDXI_W-1:0] LIMIT = IDXI_W'(NUM_ENTRIES);

    assert_cu_R1: assert property (@(posedge clk) disable iff (rst)
        wr_stb && !cop_en |=> cu_o && !done_o);

    assert_ri_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb && cop_en && !vz_cap |=> ri_o && !done_o);

    assert_nomc_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb && eh_inv |=> !mcheck_o);

    assert_dup_R9: assert property (@(posedge clk) disable iff (rst)
        dup_o |-> done_o && !mcheck_o);

    assert_idx_R10: assert property (@(posedge clk) disable iff (rst)
        wr_stb && cop_en && vz_cap && (idx_in >= LIMIT) |=> idx_err_o && !done_o);

    assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o && $stable(rd_idx) && !$past(rst) |-> $stable(rd_vpn2) && $stable(rd_hwinv));

    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cu_o, ri_o, idx_err_o, mcheck_o, done_o}));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> !cu_o && !ri_o && !idx_err_o && !mcheck_o && !done_o && !dup_o);

endmodule

bind tlbgw_top tlbgw_props #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDXI_W      (IDXI_W),
    .IW          (IW)
) u_props (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .cop_en    (cop_en),
    .vz_cap    (vz_cap),
    .eh_inv    (eh_inv),
    .idx_in    (idx_in),
    .cu_o      (cu_o),
    .ri_o      (ri_o),
    .idx_err_o (idx_err_o),
    .mcheck_o  (mcheck_o),
    .done_o    (done_o),
    .dup_o     (dup_o),
    .rd_idx    (rd_idx),
    .rd_vpn2   (rd_vpn2),
    .rd_hwinv  (rd_hwinv)
);

// File: tb/test_tlbgw_top.sv
module test_tlbgw_top;
    import tlbgw_pkg::*;

    localparam int N    = 16;
    localparam int VARN = 8;
    localparam int IXW  = 6;
    localparam int IW   = 4;
    localparam int FIW  = 3;
    localparam logic [MASK_W-1:0] FMASK = 8'h03;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0, cop_en = 1'b1, vz_cap = 1'b1, gid_en = 1'b0, eh_inv = 1'b0;
    logic [1:0]        inv_lvl = '0;
    logic [GID_W-1:0]  root_gid = '0;
    logic [IXW-1:0]    idx_in = '0;
    logic [VPN2_W-1:0] eh_vpn2 = '0;
    logic [ASID_W-1:0] eh_asid = '0;
    logic [RGN_W-1:0]  eh_r = '0;
    logic [PFN_W-1:0]  lo0_pfn = '0, lo1_pfn = '0;
    logic [CA_W-1:0]   lo0_c = '0, lo1_c = '0;
    logic lo0_d = 1'b0, lo0_v = 1'b0, lo0_g = 1'b0, lo1_d = 1'b0, lo1_v = 1'b0, lo1_g = 1'b0;
    logic [MASK_W-1:0] pg_mask = '0;
    logic cu_o, ri_o, idx_err_o, mcheck_o, done_o, dup_o;
    logic [IW-1:0]     rd_idx = '0;
    logic [VPN2_W-1:0] rd_vpn2;
    logic [ASID_W-1:0] rd_asid;
    logic [RGN_W-1:0]  rd_r;
    logic [MASK_W-1:0] rd_mask;
    logic              rd_g, rd_d0, rd_v0, rd_d1, rd_v1, rd_hwinv;
    logic [PFN_W-1:0]  rd_pfn0, rd_pfn1;
    logic [CA_W-1:0]   rd_c0, rd_c1;
    logic [GID_W-1:0]  rd_gid;

    tlbgw_top #(.NUM_ENTRIES(N), .VAR_ENTRIES(VARN), .IDXI_W(IXW), .FIX_MASK(FMASK))
        i_tlbgw_top (.*);

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    entry_t m [N];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic scan_table();
        @(negedge clk);
        chk("R11", "flags idle", {cu_o, ri_o, idx_err_o, mcheck_o, done_o, dup_o}, 0);
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            #1;
            chk("R4", "vpn2/pfn", {rd_vpn2, rd_pfn0, rd_pfn1}, {m[i].vpn2, m[i].p0.pfn, m[i].p1.pfn});
            chk("R12", "mask readback", rd_mask, m[i].mask);
            chk("R3", "global", rd_g, m[i].g);
            chk("R5", "attrs", {rd_asid, rd_r, rd_c0, rd_d0, rd_v0, rd_c1, rd_d1, rd_v1},
                {m[i].asid, m[i].r, m[i].p0.c, m[i].p0.d, m[i].p0.v, m[i].p1.c, m[i].p1.d, m[i].p1.v});
            chk("R6", "hwinv", rd_hwinv, m[i].hwinv);
            chk("R7", "gid", rd_gid, m[i].gid);
            @(negedge clk);
        end
    endtask

    // Reference model built from the requirements; returns {cu,ri,idx,mc,done,dup}
    function automatic logic [5:0] model_step();
        logic [5:0] f = '0;
        logic fixbad;
        logic [IXW-1:0] off;
        entry_t ne;
        logic [IW-1:0] s;
        logic [VPN2_W-1:0] care;
        if (!cop_en) f[5] = 1'b1;
        else if (!vz_cap) f[4] = 1'b1;
        else if (idx_in >= IXW'(N)) f[3] = 1'b1;
        else begin
            s = idx_in[IW-1:0];
            off = idx_in - IXW'(VARN);
            fixbad = (idx_in >= IXW'(VARN)) && ((pg_mask != FMASK) || (eh_vpn2[FIW-1:0] != off[FIW-1:0]));
            if (fixbad && !eh_inv) f[2] = 1'b1;
            else begin
                f[1] = 1'b1;
                ne.vpn2 = eh_vpn2 & ~{{(VPN2_W-MASK_W){1'b0}}, pg_mask};
                ne.asid = eh_asid;
                ne.r = eh_r;
                ne.mask = pg_mask;
                ne.g = lo0_g & lo1_g;
                ne.p0.pfn = lo0_pfn & ~{{(PFN_W-MASK_W){1'b0}}, pg_mask};
                ne.p0.c = lo0_c; ne.p0.d = lo0_d; ne.p0.v = lo0_v;
                ne.p1.pfn = lo1_pfn & ~{{(PFN_W-MASK_W){1'b0}}, pg_mask};
                ne.p1.c = lo1_c; ne.p1.d = lo1_d; ne.p1.v = lo1_v;
                ne.gid = gid_en ? root_gid : m[s].gid;
                ne.hwinv = (inv_lvl >= 2) ? eh_inv : m[s].hwinv;
                if (!eh_inv) begin
                    for (int j = 0; j < N; j++) begin
                        care = ~{{(VPN2_W-MASK_W){1'b0}}, (m[j].mask | ne.mask)};
                        if (j != int'(s) && !m[j].hwinv && m[j].r == ne.r && m[j].gid == ne.gid &&
                            (m[j].g || ne.g || m[j].asid == ne.asid) &&
                            (((m[j].vpn2 ^ ne.vpn2) & care) == '0)) begin
                            m[j].hwinv = 1'b1;
                            f[0] = 1'b1;
                        end
                    end
                end
                m[s] = ne;
            end
        end
        return f;
    endfunction

    task automatic do_write();
        logic [5:0] exp;
        exp = model_step();
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk("R1", "cu_o", cu_o, exp[5]);
        chk("R2", "ri_o", ri_o, exp[4]);
        chk("R10", "idx_err_o", idx_err_o, exp[3]);
        chk("R8", "mcheck_o", mcheck_o, exp[2]);
        chk("R11", "done_o", done_o, exp[1]);
        chk("R9", "dup_o", dup_o, exp[0]);
        scan_table();
    endtask

    task automatic base_fields();
        cop_en = 1; vz_cap = 1; inv_lvl = 2; gid_en = 1; root_gid = 4'h1; eh_inv = 0;
        eh_asid = 8'h11; eh_r = 2'd1; pg_mask = 8'h00;
        lo0_pfn = 20'hABCDE; lo0_c = 3'd3; lo0_d = 1; lo0_v = 1; lo0_g = 1;
        lo1_pfn = 20'h12345; lo1_c = 3'd5; lo1_d = 0; lo1_v = 1; lo1_g = 1;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < N; i++) m[i] = reset_entry();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        scan_table();
        // R1: coprocessor disabled
        base_fields(); cop_en = 0; idx_in = 2; eh_vpn2 = 19'h1234; do_write();
        // R2: no virtualization capability
        base_fields(); vz_cap = 0; idx_in = 2; do_write();
        // R10: index out of range
        base_fields(); idx_in = 20; do_write();
        // R3, R4: mask clearing and global AND
        base_fields(); idx_in = 2; eh_vpn2 = '1; pg_mask = 8'h0F; lo1_g = 0; do_write();
        // R8: fixed region, wrong size
        base_fields(); idx_in = 9; eh_vpn2 = 19'h00051; pg_mask = 8'h0F; do_write();
        // R8: fixed region, VPN inconsistent with index
        base_fields(); idx_in = 9; eh_vpn2 = 19'h00050; pg_mask = FMASK; do_write();
        // R8: same fault suppressed by the invalidate flag
        base_fields(); idx_in = 9; eh_vpn2 = 19'h00050; pg_mask = FMASK; eh_inv = 1; do_write();
        // R9: duplicate invalidated
        base_fields(); idx_in = 3; eh_vpn2 = 19'h00700; do_write();
        base_fields(); idx_in = 4; eh_vpn2 = 19'h00700; do_write();
        // R6, R7: inv level below 2 and guest ID disabled retain prior values
        base_fields(); idx_in = 5; inv_lvl = 1; gid_en = 0; eh_inv = 1; eh_vpn2 = 19'h00900; do_write();
        // Random mix
        for (int t = 0; t < 300; t++) begin
            cop_en   = ($urandom % 10) != 0;
            vz_cap   = ($urandom % 10) != 0;
            inv_lvl  = 2'($urandom);
            gid_en   = 1'($urandom);
            root_gid = GID_W'($urandom % 2);
            eh_inv   = ($urandom % 5) == 0;
            idx_in   = (($urandom % 8) != 0) ? IXW'($urandom % N) : IXW'($urandom);
            eh_vpn2  = VPN2_W'(($urandom % 4) << 4);
            if ($urandom % 2) eh_vpn2[FIW-1:0] = idx_in[FIW-1:0];
            else eh_vpn2[FIW-1:0] = FIW'($urandom);
            eh_asid  = ASID_W'($urandom % 3);
            eh_r     = RGN_W'($urandom % 2);
            case ($urandom % 3)
                0: pg_mask = 8'h00;
                1: pg_mask = FMASK;
                default: pg_mask = 8'h0F;
            endcase
            lo0_pfn = PFN_W'($urandom); lo0_c = CA_W'($urandom); lo0_d = 1'($urandom);
            lo0_v = 1'($urandom); lo0_g = ($urandom % 4) == 0;
            lo1_pfn = PFN_W'($urandom); lo1_c = CA_W'($urandom); lo1_d = 1'($urandom);
            lo1_v = 1'($urandom); lo1_g = ($urandom % 2) == 0;
            do_write();
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule